// File: doc/BRIEF.md
# Closed-Loop Supply Trim Controller

This block holds a power supply output at a programmed target voltage. On a fixed control interval it requests one conversion from an external ADC that samples the load voltage. When the conversion returns, the block compares the result with a set-point held in ADC code units. It then moves the trim DAC code one step. A sample above the target lowers the code, a sample below raises it, and a sample equal to the target leaves the code alone. The code saturates at both ends of its range. A one-cycle strobe goes out with every change, so a downstream DAC interface can latch the new value.

A small parallel register port stands in for the host bus. Through this port the host can open the loop and own the DAC code, which is how margining is done. The host can also move the set-point and read back the latest sample at any time. A conversion that is still outstanding when the next interval begins is abandoned without a step, and a sticky flag records it. The block leaves reset with the loop open and the code at mid-scale, so no trimming happens until the host closes the loop.

Top module: `trim_loop_ctrl`

## Requirements
- R1: After reset the loop is open, the set-point reads 0, the timeout flag reads 0, the sample reads 0, and the DAC code is mid-scale (2^(DAC_W-1), which is 128 for DAC_W=8).
- R2: `adc_start` is a one-cycle pulse repeated every PERIOD_CYCLES clocks, where PERIOD_CYCLES = CLK_KHZ*PERIOD_US/1000. It pulses in both loop modes.
- R3: With the loop closed, an accepted sample greater than the set-point lowers the DAC code by one.
- R4: With the loop closed, an accepted sample less than the set-point raises the DAC code by one.
- R5: With the loop closed, a sample equal to the set-point leaves the DAC code unchanged and produces no strobe.
- R6: The code saturates instead of wrapping. It stays at 2^DAC_W-1 on a raise request and stays at 0 on a lower request.
- R7: With the loop open (control register bit 0 = 0), samples never change the code. A host write to register 2 loads the code from `host_wdata[DAC_W-1:0]`.
- R8: Register 3 returns the last accepted sample, which is the `adc_data` value seen with `adc_done` while a conversion was outstanding. This holds in either mode.
- R9: If no `adc_done` arrives before the next `adc_start`, that interval applies no step and sets a sticky flag that reads as control register bit 1. The flag is cleared by writing register 0 with bit 1 set. A done that arrives in the same cycle as the next start is still accepted and sets no flag.
- R10: Closing the loop again resumes stepping from the code the host wrote last.
- R11: `dac_upd` is high for exactly the one cycle in which `dac_code` first shows a new value.
- R12: Register 1 holds the set-point. It is written by the host and read back unchanged.
- R13: When a host write to register 2 lands in the same cycle as an accepted sample with the loop closed, the host value wins and no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write enable |
| host_addr | input | 2 | Register select: 0 control, 1 set-point, 2 DAC code, 3 sample |
| host_wdata | input | REG_W | Write data |
| host_rdata | output | REG_W | Read data for `host_addr`, combinational |
| adc_start | output | 1 | Conversion request pulse |
| adc_done | input | 1 | Conversion complete strobe |
| adc_data | input | ADC_W | Conversion result, valid with `adc_done` |
| dac_code | output | DAC_W | Trim DAC code |
| dac_upd | output | 1 | One-cycle strobe on each code change |

## Verification
Two pairs of events can collide in one clock. In the first pair, a conversion completes in the very cycle that begins the next interval. The bench holds `adc_done` back until the cycle of the following `adc_start`. It then expects the step to be applied, the timeout flag to stay clear, and the freshly started conversion to be answered normally. In the second pair, a host code write coincides with an accepted sample while the loop is closed. The scoreboard expects only the host value on the strobe, with no extra step queued after it.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_SETPT  = 2'd1,
    REG_DAC    = 2'd2,
    REG_SAMPLE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CMP_EQ   = 2'd0,
    CMP_HIGH = 2'd1,
    CMP_LOW  = 2'd2
  } cmp_e;

  // Direction of the measured value relative to the target
  function automatic cmp_e compare_sample(input logic [31:0] meas,
                                          input logic [31:0] target);
    if (meas > target) return CMP_HIGH;
    if (meas < target) return CMP_LOW;
    return CMP_EQ;
  endfunction

  // One saturating step of the trim code
  function automatic logic [31:0] step_code(input logic [31:0] cur,
                                            input cmp_e dir,
                                            input logic [31:0] top);
    logic [31:0] res;
    res = cur;
    case (dir)
      CMP_HIGH: if (cur != 32'd0) res = cur - 32'd1;
      CMP_LOW:  if (cur < top)    res = cur + 32'd1;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/trim_period_timer.sv
module trim_period_timer #(
  parameter int PERIOD_CYCLES = 58000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/trim_adc_seq.sv
module trim_adc_seq #(
  parameter int ADC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             adc_done,
  input  logic [ADC_W-1:0] adc_data,
  input  logic             clr_timeout,
  output logic             adc_start,
  output logic             done_evt,
  output logic             timeout_evt,
  output logic             timeout_flag,
  output logic [ADC_W-1:0] sample_q
);
  logic pending_q;

  assign adc_start   = tick;
  assign done_evt    = adc_done & pending_q;
  assign timeout_evt = tick & pending_q & ~adc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q    <= 1'b0;
      timeout_flag <= 1'b0;
      sample_q     <= '0;
    end else begin
      if (tick)          pending_q <= 1'b1;
      else if (done_evt) pending_q <= 1'b0;
      if (done_evt) sample_q <= adc_data;
      if (timeout_evt)      timeout_flag <= 1'b1;
      else if (clr_timeout) timeout_flag <= 1'b0;
    end
  end

  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> pending_q);

  // R9
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !clr_timeout) |=> timeout_flag);

  // R9
  timeout_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> timeout_flag);

  // R8
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(sample_q));

endmodule

// File: rtl/trim_dac_reg.sv
module trim_dac_reg
  import trim_pkg::*;
#(
  parameter int DAC_W = 8,
  parameter int ADC_W = 12,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_en,
  input  logic             done_evt,
  input  logic [ADC_W-1:0] meas,
  input  logic [REG_W-1:0] setpoint,
  input  logic             host_ld,
  input  logic [DAC_W-1:0] host_code,
  output logic [DAC_W-1:0] code,
  output logic             upd,
  output logic             step_evt
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1 << (DAC_W - 1));
  localparam logic [DAC_W-1:0] TOP = {DAC_W{1'b1}};

  cmp_e             dir;
  logic [DAC_W-1:0] stepped;
  logic [DAC_W-1:0] nxt;

  assign step_evt = loop_en & done_evt & ~host_ld;
  assign dir      = compare_sample(32'(meas), 32'(setpoint));
  assign stepped  = DAC_W'(step_code(32'(code), dir, 32'(TOP)));

  always_comb begin
    if (host_ld)       nxt = host_code;
    else if (step_evt) nxt = stepped;
    else               nxt = code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= MID;
      upd  <= 1'b0;
    end else begin
      code <= nxt;
      upd  <= (nxt != code);
    end
  end

  // R7
  open_loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !host_ld) |=> $stable(code));

  // R3 R4 R6
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ld |=> ((code == $past(code)) || (code == $past(code) + 1'b1) ||
                  (code == $past(code) - 1'b1)));

  // R13
  host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ld |=> (code == $past(host_code)));

  // R11
  upd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd == (code != $past(code)));

endmodule

// File: rtl/trim_loop_ctrl.sv
module trim_loop_ctrl
  import trim_pkg::*;
#(
  parameter int CLK_KHZ   = 100000,
  parameter int PERIOD_US = 580,
  parameter int ADC_W     = 12,
  parameter int DAC_W     = 8,
  parameter int REG_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [1:0]       host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  output logic             adc_start,
  input  logic             adc_done,
  input  logic [ADC_W-1:0] adc_data,
  output logic [DAC_W-1:0] dac_code,
  output logic             dac_upd
);
  localparam int PERIOD_CYCLES = CLK_KHZ * PERIOD_US / 1000;

  reg_sel_e         sel;
  logic             loop_en_q;
  logic [REG_W-1:0] setpt_q;
  logic             tick;
  logic             done_evt;
  logic             timeout_evt;
  logic             timeout_flag;
  logic [ADC_W-1:0] sample_q;
  logic             step_evt;
  logic             wr_ctrl, wr_setpt, wr_dac;

  assign sel      = reg_sel_e'(host_addr);
  assign wr_ctrl  = host_wr && (sel == REG_CTRL);
  assign wr_setpt = host_wr && (sel == REG_SETPT);
  assign wr_dac   = host_wr && (sel == REG_DAC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_en_q <= 1'b0;
      setpt_q   <= '0;
    end else begin
      if (wr_ctrl)  loop_en_q <= host_wdata[0];
      if (wr_setpt) setpt_q   <= host_wdata;
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL:  host_rdata = REG_W'({timeout_flag, loop_en_q});
      REG_SETPT: host_rdata = setpt_q;
      REG_DAC:   host_rdata = REG_W'(dac_code);
      default:   host_rdata = REG_W'(sample_q);
    endcase
  end

  trim_period_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  trim_adc_seq #(.ADC_W(ADC_W)) u_adc (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .adc_done     (adc_done),
    .adc_data     (adc_data),
    .clr_timeout  (wr_ctrl & host_wdata[1]),
    .adc_start    (adc_start),
    .done_evt     (done_evt),
    .timeout_evt  (timeout_evt),
    .timeout_flag (timeout_flag),
    .sample_q     (sample_q)
  );

  trim_dac_reg #(.DAC_W(DAC_W), .ADC_W(ADC_W), .REG_W(REG_W)) u_dac (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_en   (loop_en_q),
    .done_evt  (done_evt),
    .meas      (adc_data),
    .setpoint  (setpt_q),
    .host_ld   (wr_dac),
    .host_code (host_wdata[DAC_W-1:0]),
    .code      (dac_code),
    .upd       (dac_upd),
    .step_evt  (step_evt)
  );

  // R9
  no_step_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> !step_evt);

  // R12
  setpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_setpt |=> $stable(setpt_q));

endmodule

// File: tb/trim_loop_ctrl_bench.sv
module trim_loop_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int PERIOD = 58;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        adc_start;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic [7:0]  dac_code;
  logic        dac_upd;

  int total = 0;
  int bad = 0;
  int exp_code = 128;
  int setpt_m = 0;
  bit loop_on = 0;
  bit finished = 0;
  int exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  trim_loop_ctrl #(.CLK_KHZ(100), .PERIOD_US(580)) u_trim_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .adc_start(adc_start),
    .adc_done(adc_done), .adc_data(adc_data), .dac_code(dac_code),
    .dac_upd(dac_upd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_step(input int c, input int s, input int sp);
    if (s == sp) return c;
    if (s < sp)  return (c == 255) ? 255 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  // expected strobes are queued in the same cycle the cause is driven
  task automatic expect_code(input int v);
    if (v != exp_code) exp_q.push_back(v);
    exp_code = v;
  endtask

  task automatic host_write(input int a, input int d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 2'(a); host_wdata = 16'(d);
    if (a == 2) expect_code(d & 255);
    if (a == 0) loop_on = d[0];
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input int a, output int v);
    @(negedge clk);
    host_addr = 2'(a);
    #1 v = int'(host_rdata);
  endtask

  task automatic wait_start();
    @(negedge clk);
    while (!adc_start) @(negedge clk);
  endtask

  task automatic answer(input int val);
    adc_done = 1'b1; adc_data = 12'(val);
    if (loop_on) expect_code(model_step(exp_code, val, setpt_m));
    @(negedge clk);
    adc_done = 1'b0;
  endtask

  task automatic run_period(input int val, input int dly);
    wait_start();
    repeat (dly) @(negedge clk);
    answer(val);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && dac_upd) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected strobe", int'(dac_code), exp_code);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(dac_code) == e, "R11 strobe value", int'(dac_code), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    host_read(0, v); chk(v == 0,   "R1 ctrl",     v, 0);
    host_read(1, v); chk(v == 0,   "R1 setpoint", v, 0);
    host_read(2, v); chk(v == 128, "R1 dac",      v, 128);
    host_read(3, v); chk(v == 0,   "R1 sample",   v, 0);

    run_period(500, 3);
    chk(int'(dac_code) == 128, "R7 open loop hold", int'(dac_code), 128);
    host_read(3, v); chk(v == 500, "R8 open loop sample", v, 500);

    wait_start();
    n = 0;
    do begin @(negedge clk); n++; end while (!adc_start);
    chk(n == PERIOD, "R2 interval", n, PERIOD);
    @(negedge clk);
    host_read(0, v); chk(v[1] == 1'b1, "R9 timeout flag", v, 2);
    chk(int'(dac_code) == 128, "R9 no step", int'(dac_code), 128);
    answer(77);
    host_read(3, v); chk(v == 77, "R8 sample", v, 77);
    host_write(0, 2);
    host_read(0, v); chk(v == 0, "R9 clear", v, 0);

    host_write(1, 1000); setpt_m = 1000;
    host_read(1, v); chk(v == 1000, "R12 setpoint", v, 1000);
    host_write(0, 1);

    run_period(1200, 4); chk(int'(dac_code) == 127, "R3 lower", int'(dac_code), 127);
    run_period(800, 2);  chk(int'(dac_code) == 128, "R4 raise", int'(dac_code), 128);
    run_period(1000, 5); chk(int'(dac_code) == 128, "R5 equal", int'(dac_code), 128);

    host_write(2, 254);
    run_period(0, 3); chk(int'(dac_code) == 255, "R4 raise to top", int'(dac_code), 255);
    run_period(0, 3); chk(int'(dac_code) == 255, "R6 top saturate", int'(dac_code), 255);
    host_write(2, 1);
    run_period(4000, 3); chk(int'(dac_code) == 0, "R3 lower to zero", int'(dac_code), 0);
    run_period(4000, 3); chk(int'(dac_code) == 0, "R6 zero saturate", int'(dac_code), 0);

    host_write(0, 0);
    host_write(2, 50);
    run_period(0, 3); chk(int'(dac_code) == 50, "R7 host owns code", int'(dac_code), 50);
    host_write(0, 1);
    run_period(0, 3); chk(int'(dac_code) == 51, "R10 resume", int'(dac_code), 51);

    // done lands in the cycle of the next adc_start
    host_write(0, 3);
    wait_start();
    repeat (PERIOD) @(negedge clk);
    chk(adc_start == 1'b1, "R9 boundary start", int'(adc_start), 1);
    answer(0);
    repeat (3) @(negedge clk);
    answer(0);
    host_read(0, v); chk(v == 1, "R9 boundary no timeout", v, 1);
    chk(int'(dac_code) == 53, "R9 boundary steps", int'(dac_code), 53);

    // host write collides with an accepted sample
    wait_start();
    repeat (3) @(negedge clk);
    host_wr = 1'b1; host_addr = 2'd2; host_wdata = 16'd200;
    expect_code(200);
    adc_done = 1'b1; adc_data = 12'd4000;
    @(negedge clk);
    host_wr = 1'b0; adc_done = 1'b0;
    repeat (2) @(negedge clk);
    chk(int'(dac_code) == 200, "R13 host wins", int'(dac_code), 200);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R11 missing strobes", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule